// File: doc/BRIEF.md
# Pulse-Per-Second Disciplined Fractional Clock Divider

This block turns a free-running reference clock of roughly 4 MHz, whose exact rate is unknown, into a 32.768 kHz timing stream. It splits the reference into output periods of two neighbouring integer lengths. The long ones are spread by an error accumulator so that every run of `OUT_RATE` periods takes exactly `M` reference cycles. `M` is the number of reference cycles measured between two rising edges of a once-per-second timing pulse.

Each accepted measurement retunes the short length and the number of long periods, so the output carries no error over the long term. A measurement far from nominal, or a pulse that fails to arrive, leaves the divider running on its last good setting and drops the lock indication. The last measured interval is always visible on an output.

Top module: `pps_frac_divider`

## Requirements
- R1: After reset, `locked` and `meas_count` are 0, `tick_out` is high in the first cycle, and the divider runs from the nominal count `NOM_COUNT`.
- R2: Every output period lasts `N` or `N+1` reference cycles, where `N = M / OUT_RATE` (integer division, `OUT_RATE` a power of two) and `M` is the count in force.
- R3: Any `OUT_RATE` consecutive output periods that begin after a setting takes effect add up to exactly `M` reference cycles. Exactly `K = M mod OUT_RATE` of those periods are long.
- R4: `tick_out` is high for exactly one cycle, the first cycle of each period. `clk_out` is high for the first `floor(L/2)` cycles of a period of length `L` and low for the rest.
- R5: `pps_in` passes through a two-stage synchroniser before its rising edge is detected. The first rising edge after reset, or after a timeout, only arms the measurement and changes neither `locked` nor `meas_count`.
- R6: On every armed rising edge, `meas_count` takes the number of reference cycles since the previous rising edge, whether or not that value is accepted.
- R7: A measured count within `NOM_COUNT ± TOL_COUNT` (both ends included) sets `locked`. Its `N` and `K` govern from the next period start, with the accumulator cleared.
- R8: A measured count outside that window clears `locked` and leaves the period pattern unchanged.
- R9: If no rising edge arrives within `TIMEOUT` cycles of the last one, `locked` clears, the period pattern is kept, and the measurement disarms.
- R10: A new setting never cuts short or stretches a running period: no period falls outside the range of lengths the acceptance window allows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pps_in | input | 1 | Asynchronous once-per-second timing pulse |
| tick_out | output | 1 | One-cycle strobe at the start of each output period |
| clk_out | output | 1 | Output square wave, high in the first half of each period |
| locked | output | 1 | Last interval was accepted and no timeout has occurred since |
| meas_count | output | $clog2(TIMEOUT+1) | Last measured interval, in reference cycles |

## Verification
The bench reduces the rate to 16 periods per "second" of about 200 cycles. It can then compare whole windows of 16 periods against the measured count, which exposes any accumulator that drops or doubles a long period as a sum that is one length off. It accepts intervals at both edges of the window and rejects intervals one cycle beyond each edge, which catches a range compare that is off by one or uses the wrong direction. It also checks that the rejected and timed-out cases keep the old pattern, so a design that loaded every measurement would show the rejected count in the period sums. Finally, it confirms that the first edge after disarming only arms, because a design that skipped arming would lock to a count taken from an undefined start.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
    // Outcome of the interval meter in the current cycle.
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_GOOD = 2'd1,
        EV_BAD  = 2'd2,
        EV_MISS = 2'd3
    } meas_ev_e;
endpackage

// File: rtl/pfd_pps_sync.sv
module pfd_pps_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pps_async,
    output logic pps_rise
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t sync_q, sync_d;

    always_comb begin
        sync_d.s1   = pps_async;
        sync_d.s2   = sync_q.s1;
        sync_d.prev = sync_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign pps_rise = sync_q.s2 & ~sync_q.prev;
endmodule

// File: rtl/pfd_period_meter.sv
module pfd_period_meter
    import pfd_pkg::*;
#(
    parameter int CW        = 23,
    parameter int NOM_COUNT = 4_000_000,
    parameter int TOL_COUNT = 800,
    parameter int TIMEOUT   = 6_000_000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pps_rise,
    output meas_ev_e      ev,
    output logic [CW-1:0] m_now,
    output logic [CW-1:0] meas_last
);
    localparam logic [CW-1:0] LO_LIM  = CW'(NOM_COUNT - TOL_COUNT);
    localparam logic [CW-1:0] HI_LIM  = CW'(NOM_COUNT + TOL_COUNT);
    localparam logic [CW-1:0] TMO_LIM = CW'(TIMEOUT);

    typedef struct packed {
        logic          armed;
        logic [CW-1:0] cnt;
        logic [CW-1:0] meas;
    } meter_t;

    meter_t mt_q, mt_d;

    always_comb begin
        mt_d = mt_q;
        ev   = EV_NONE;
        if (mt_q.armed) mt_d.cnt = mt_q.cnt + 1'b1;
        if (pps_rise) begin
            mt_d.armed = 1'b1;
            mt_d.cnt   = CW'(1);
            if (mt_q.armed) begin
                mt_d.meas = mt_q.cnt;
                ev = (mt_q.cnt >= LO_LIM && mt_q.cnt <= HI_LIM) ? EV_GOOD : EV_BAD;
            end
        end else if (mt_q.armed && mt_q.cnt >= TMO_LIM) begin
            mt_d.armed = 1'b0;
            ev         = EV_MISS;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mt_q <= '0;
        else        mt_q <= mt_d;
    end

    assign m_now     = mt_q.cnt;
    assign meas_last = mt_q.meas;
endmodule

// File: rtl/pfd_frac_gen.sv
module pfd_frac_gen #(
    parameter int CW        = 23,
    parameter int OUT_RATE  = 32768,
    parameter int NOM_COUNT = 4_000_000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] m_new,
    output logic          tick,
    output logic          sq
);
    localparam int FR_W = $clog2(OUT_RATE);
    localparam int NW   = CW - FR_W;
    localparam int LW   = NW + 1;
    localparam logic [FR_W:0]   RATE = (FR_W+1)'(OUT_RATE);
    localparam logic [NW-1:0]   N0   = NW'(NOM_COUNT / OUT_RATE);
    localparam logic [FR_W-1:0] K0   = FR_W'(NOM_COUNT % OUT_RATE);

    typedef struct packed {
        logic [LW-1:0]   phase;
        logic [LW-1:0]   len;
        logic [FR_W-1:0] acc;
        logic [NW-1:0]   cur_n;
        logic [FR_W-1:0] cur_k;
        logic            pend;
        logic [NW-1:0]   pend_n;
        logic [FR_W-1:0] pend_k;
    } gen_t;

    gen_t gq, gd;

    logic            wrap;
    logic            fresh;
    logic [NW-1:0]   sel_n;
    logic [FR_W-1:0] sel_k;
    logic [FR_W:0]   sum;

    always_comb begin
        gd   = gq;
        wrap = (gq.phase == gq.len - 1'b1);
        if (load) begin
            sel_n = m_new[CW-1:FR_W];
            sel_k = m_new[FR_W-1:0];
            fresh = 1'b1;
        end else if (gq.pend) begin
            sel_n = gq.pend_n;
            sel_k = gq.pend_k;
            fresh = 1'b1;
        end else begin
            sel_n = gq.cur_n;
            sel_k = gq.cur_k;
            fresh = 1'b0;
        end
        sum = (fresh ? {(FR_W+1){1'b0}} : {1'b0, gq.acc}) + {1'b0, sel_k};
        if (wrap) begin
            gd.phase = '0;
            if (sum >= RATE) begin
                gd.len = {1'b0, sel_n} + 1'b1;
                gd.acc = FR_W'(sum - RATE);
            end else begin
                gd.len = {1'b0, sel_n};
                gd.acc = sum[FR_W-1:0];
            end
            gd.cur_n = sel_n;
            gd.cur_k = sel_k;
            gd.pend  = 1'b0;
        end else begin
            gd.phase = gq.phase + 1'b1;
            if (load) begin
                gd.pend   = 1'b1;
                gd.pend_n = m_new[CW-1:FR_W];
                gd.pend_k = m_new[FR_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gq.phase  <= '0;
            gq.len    <= {1'b0, N0};
            gq.acc    <= K0;
            gq.cur_n  <= N0;
            gq.cur_k  <= K0;
            gq.pend   <= 1'b0;
            gq.pend_n <= '0;
            gq.pend_k <= '0;
        end else begin
            gq <= gd;
        end
    end

    assign tick = (gq.phase == '0);
    assign sq   = (gq.phase < (gq.len >> 1));
endmodule

// File: rtl/pps_frac_divider.sv
module pps_frac_divider
    import pfd_pkg::*;
#(
    parameter int NOM_COUNT = 4_000_000,
    parameter int OUT_RATE  = 32768,
    parameter int TOL_COUNT = 800,
    parameter int TIMEOUT   = 6_000_000,
    localparam int CW       = $clog2(TIMEOUT + 1)
) (
    input  logic          clk_ref,
    input  logic          rst_n,
    input  logic          pps_in,
    output logic          tick_out,
    output logic          clk_out,
    output logic          locked,
    output logic [CW-1:0] meas_count
);
    logic          pps_rise;
    meas_ev_e      ev;
    logic [CW-1:0] m_now;
    logic          lock_q, lock_d;

    pfd_pps_sync sync_i (
        .clk       (clk_ref),
        .rst_n     (rst_n),
        .pps_async (pps_in),
        .pps_rise  (pps_rise)
    );

    pfd_period_meter #(
        .CW        (CW),
        .NOM_COUNT (NOM_COUNT),
        .TOL_COUNT (TOL_COUNT),
        .TIMEOUT   (TIMEOUT)
    ) meter_i (
        .clk       (clk_ref),
        .rst_n     (rst_n),
        .pps_rise  (pps_rise),
        .ev        (ev),
        .m_now     (m_now),
        .meas_last (meas_count)
    );

    pfd_frac_gen #(
        .CW        (CW),
        .OUT_RATE  (OUT_RATE),
        .NOM_COUNT (NOM_COUNT)
    ) gen_i (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .load  (ev == EV_GOOD),
        .m_new (m_now),
        .tick  (tick_out),
        .sq    (clk_out)
    );

    always_comb begin
        lock_d = lock_q;
        case (ev)
            EV_GOOD:          lock_d = 1'b1;
            EV_BAD, EV_MISS:  lock_d = 1'b0;
            default:          lock_d = lock_q;
        endcase
    end

    always_ff @(posedge clk_ref) begin
        if (!rst_n) lock_q <= 1'b0;
        else        lock_q <= lock_d;
    end

    assign locked = lock_q;
endmodule

// File: rtl/pfd_checker.sv
module pfd_checker #(
    parameter int CW        = 23,
    parameter int NOM_COUNT = 4_000_000,
    parameter int OUT_RATE  = 32768,
    parameter int TOL_COUNT = 800
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          sq,
    input logic          locked,
    input logic [CW-1:0] meas,
    input logic          pps_rise
);
    localparam int MIN_LEN = (NOM_COUNT - TOL_COUNT) / OUT_RATE;
    localparam int MAX_LEN = (NOM_COUNT + TOL_COUNT) / OUT_RATE + 1;
    localparam logic [CW-1:0] LO_LIM = CW'(NOM_COUNT - TOL_COUNT);
    localparam logic [CW-1:0] HI_LIM = CW'(NOM_COUNT + TOL_COUNT);

    logic [31:0] gap_q, gap_d;
    logic        seen_q, seen_d;

    always_comb begin
        seen_d = seen_q | tick;
        if (tick)                 gap_d = 32'd1;
        else if (gap_q != '1)     gap_d = gap_q + 32'd1;
        else                      gap_d = gap_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            gap_q  <= gap_d;
            seen_q <= seen_d;
        end
    end

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);                                            // R4
    AST_SQ_HIGH_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> sq);                                               // R4
    AST_PERIOD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && seen_q) |-> (gap_q >= 32'(MIN_LEN) && gap_q <= 32'(MAX_LEN))); // R10
    AST_LOCK_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> (meas >= LO_LIM && meas <= HI_LIM));      // R7
    AST_LOCK_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(pps_rise));                         // R5
    AST_MEAS_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(meas) |-> $past(pps_rise));                        // R6
endmodule

bind pps_frac_divider pfd_checker #(
    .CW        (CW),
    .NOM_COUNT (NOM_COUNT),
    .OUT_RATE  (OUT_RATE),
    .TOL_COUNT (TOL_COUNT)
) chk_i (
    .clk      (clk_ref),
    .rst_n    (rst_n),
    .tick     (tick_out),
    .sq       (clk_out),
    .locked   (locked),
    .meas     (meas_count),
    .pps_rise (pps_rise)
);

// File: tb/pps_frac_divider_tb_top.sv
module pps_frac_divider_tb_top;
    localparam int NOM  = 200;
    localparam int RATE = 16;
    localparam int TOL  = 10;
    localparam int TMO  = 300;
    localparam int MW   = $clog2(TMO + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pps = 1'b0;
    logic          tick, sqw, locked;
    logic [MW-1:0] meas;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pps_frac_divider #(
        .NOM_COUNT (NOM),
        .OUT_RATE  (RATE),
        .TOL_COUNT (TOL),
        .TIMEOUT   (TMO)
    ) dut_i (
        .clk_ref    (clk_ref_w),
        .rst_n      (rst_n),
        .pps_in     (pps),
        .tick_out   (tick),
        .clk_out    (sqw),
        .locked     (locked),
        .meas_count (meas)
    );

    logic clk_ref_w;
    assign clk_ref_w = clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Rising edge now, held high three cycles.
    task automatic pps_edge();
        pps = 1'b1;
        wait_cyc(3);
        pps = 1'b0;
    endtask

    // Measure RATE periods starting at the next tick and compare with count m.
    task automatic measure(input int m, input string req);
        int n, k, total, longs, bad_len, bad_duty;
        n = m / RATE;
        k = m % RATE;
        total = 0; longs = 0; bad_len = 0; bad_duty = 0;
        while (!tick) @(negedge clk);
        for (int p = 0; p < RATE; p++) begin
            int len, hi;
            len = 0; hi = 0;
            do begin
                if (sqw) hi++;
                len++;
                @(negedge clk);
            end while (!tick);
            total += len;
            if (len == n + 1) longs++;
            if (len != n && len != n + 1) bad_len++;
            if (hi != len / 2) bad_duty++;
        end
        check(total == m, req, "sum of periods", total, m);
        check(longs == k, req, "long period count", longs, k);
        check(bad_len == 0, "R2", "periods outside N..N+1", bad_len, 0);
        check(bad_duty == 0, "R4", "periods with wrong high time", bad_duty, 0);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        wait_cyc(5);
        rst_n = 1'b1;
        check(tick == 1'b1, "R1", "tick after reset", int'(tick), 1);
        check(locked == 1'b0, "R1", "locked after reset", int'(locked), 0);
        check(meas == '0, "R1", "meas_count after reset", int'(meas), 0);
    endtask

    task automatic test_default();
        measure(NOM, "R1");
        measure(NOM, "R3");
    endtask

    task automatic test_lock(input int gap);
        pps_edge();
        wait_cyc(5);
        check(locked == 1'b0, "R5", "locked after arming edge", int'(locked), 0);
        check(int'(meas) == 0 || int'(meas) != gap, "R5", "meas after arming edge", int'(meas), 0);
        wait_cyc(gap - 8);
        pps_edge();
        wait_cyc(3);
        check(int'(meas) == gap, "R6", "meas_count after interval", int'(meas), gap);
        check(locked == 1'b1, "R7", "locked after good interval", int'(locked), 1);
        measure(gap, "R7");
        wait_cyc(400);
    endtask

    task automatic test_reject(input int good, input int bad);
        pps_edge();
        wait_cyc(good - 3);
        pps_edge();
        wait_cyc(3);
        check(locked == 1'b1, "R7", "locked at window edge", int'(locked), 1);
        wait_cyc(bad - 6);
        pps_edge();
        wait_cyc(3);
        check(int'(meas) == bad, "R6", "meas_count of rejected interval", int'(meas), bad);
        check(locked == 1'b0, "R8", "locked after rejected interval", int'(locked), 0);
        measure(good, "R8");
        wait_cyc(400);
    endtask

    task automatic test_timeout(input int gap);
        pps_edge();
        wait_cyc(gap - 3);
        pps_edge();
        wait_cyc(247);
        check(locked == 1'b1, "R9", "locked before timeout", int'(locked), 1);
        wait_cyc(70);
        check(locked == 1'b0, "R9", "locked after timeout", int'(locked), 0);
        measure(gap, "R9");
        pps_edge();
        wait_cyc(5);
        check(locked == 1'b0, "R5", "locked after rearm edge", int'(locked), 0);
        check(int'(meas) == gap, "R5", "meas kept on rearm edge", int'(meas), gap);
        wait_cyc(400);
    endtask

    initial begin
        wait_cyc(1);
        test_reset();
        test_default();
        test_lock(205);
        test_lock(195);
        test_reject(190, 211);
        test_reject(210, 189);
        test_timeout(196);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule